// File: doc/BRIEF.md
# Infrared-Style Serial Transmit Modulator

This block shapes a serial transmit bit stream before it reaches an output pin. The raw transmit bit can first be inverted; the result can then be chopped by a carrier so that the carrier shows up only while the line would otherwise sit at logic zero, which is the usual way to drive an infrared emitter from a plain serial transmitter. The carrier has a fixed period of sixteen carrier-rate ticks, and a two-bit field picks how much of each period is spent low.

A two-bit select field then picks what actually drives the pin: the conditioned transmit stream, a general-purpose output bit, or one of two externally generated metering pulse streams (real power and reactive power). The pin value is registered, so every source reaches the pin one clock after it is presented. Configuration arrives as plain input fields that the surrounding register block holds; when those fields are all zero the pin carries the raw transmit bit unchanged.

Top module: `ir_tx_modulator`

## Requirements
- R1: While reset is asserted the pin output is 1; after reset the carrier phase starts at 0 and the active duty code starts at 00.
- R2: The pin output is registered: at each clock edge it takes the source chosen by the select field, code 0 = conditioned transmit data, 1 = general-purpose bit, 2 = real-power pulse, 3 = reactive-power pulse.
- R3: When the invert input is 1 the transmit bit is inverted before any modulation.
- R4: With modulation enabled, a conditioned transmit level of 1 reaches the pin as a steady 1; the carrier never appears on it.
- R5: With modulation enabled and a conditioned level of 0, the pin is 0 while the carrier phase (0..15) is below the low length and 1 otherwise; the low length is 8, 4, 2 or 1 for duty codes 0, 1, 2, 3.
- R6: The carrier phase advances by one, wrapping 15 to 0, only at clock edges where the tick input is 1; otherwise it holds.
- R7: The duty code in use is taken from the duty input only at a tick edge where the phase is 15, so a new duty first shapes the period that begins at phase 0.
- R8: With modulation disabled the pin (select code 0) carries the possibly inverted transmit level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| carrier_tick_i | input | 1 | One-cycle enable at the carrier sub-period rate |
| tx_bit_i | input | 1 | Raw serial transmit bit |
| tx_invert_i | input | 1 | Invert transmit bit when 1 |
| mod_enable_i | input | 1 | Enable carrier modulation when 1 |
| duty_code_i | input | 2 | Carrier low fraction: 0=8/16, 1=4/16, 2=2/16, 3=1/16 |
| pin_sel_i | input | 2 | Pin source select |
| gpo_bit_i | input | 1 | General-purpose output bit |
| real_pulse_i | input | 1 | Real-power metering pulse |
| react_pulse_i | input | 1 | Reactive-power metering pulse |
| pin_o | output | 1 | Registered pin value |

## Verification
The bench builds the block with its default carrier phase width of four bits, so one carrier period is sixteen ticks and every duty code, low run and wrap boundary is reached within a few dozen cycles. That small period lets the bench sweep every combination of select, invert, modulation enable and duty code against varied transmit, general-purpose and pulse patterns with ticks periodically withheld, while an arithmetic phase model predicts each pin value. Duty changes land at arbitrary phases across the sweep, so the deferred switch at the period boundary is exercised many times.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  localparam int unsigned DUTY_W = 2;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned NSRC   = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    PIN_SRC_TXD   = 2'd0,
    PIN_SRC_GPO   = 2'd1,
    PIN_SRC_REAL  = 2'd2,
    PIN_SRC_REACT = 2'd3
  } pin_src_e;

  typedef logic [DUTY_W-1:0] duty_t;

endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_tx_pkg::*;
#(
  parameter int unsigned PHASE_W = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  duty_t duty_i,
  output logic  carrier_low_o
);

  localparam logic [PHASE_W-1:0] PHASE_LAST = {PHASE_W{1'b1}};
  localparam logic [PHASE_W-1:0] HALF_LEN   = PHASE_W'(1) << (PHASE_W - 1);

  logic [PHASE_W-1:0] phase_q, phase_d;
  duty_t              duty_q, duty_d;
  logic [PHASE_W-1:0] low_len;
  logic               at_wrap;

  always_comb begin
    at_wrap = tick_i && (phase_q == PHASE_LAST);
    phase_d = phase_q;
    duty_d  = duty_q;
    if (tick_i) begin
      phase_d = phase_q + PHASE_W'(1);
    end
    if (at_wrap) begin
      duty_d = duty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      duty_q  <= '0;
    end else begin
      phase_q <= phase_d;
      duty_q  <= duty_d;
    end
  end

  always_comb begin
    low_len       = HALF_LEN >> duty_q;
    carrier_low_o = (phase_q < low_len);
  end

  AST_PHASE_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_q)); // R6

  AST_PHASE_STEPS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (phase_q == $past(phase_q) + PHASE_W'(1))); // R6

  AST_DUTY_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_i && phase_q == PHASE_LAST) |=> $stable(duty_q)); // R7

  AST_PERIOD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0) |-> carrier_low_o); // R5

endmodule

// File: rtl/ir_tx_shaper.sv
module ir_tx_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit_i,
  input  logic invert_i,
  input  logic mod_en_i,
  input  logic carrier_low_i,
  output logic shaped_o
);

  logic level;

  always_comb begin
    level    = tx_bit_i ^ invert_i;
    shaped_o = level;
    if (mod_en_i && !level) begin
      shaped_o = !carrier_low_i;
    end
  end

  AST_MARK_NEVER_CHOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_i != invert_i) |-> shaped_o); // R4

  AST_PLAIN_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en_i && tx_bit_i == invert_i) |-> !shaped_o); // R8

endmodule

// File: rtl/ir_pin_select.sv
module ir_pin_select
  import ir_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSRC-1:0]  src_i,
  output logic             pin_o
);

  logic pin_q, pin_d;

  always_comb begin
    pin_d = src_i[sel_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin_o = pin_q;

  AST_GPO_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == PIN_SRC_GPO) |=> (pin_o == $past(src_i[PIN_SRC_GPO]))); // R2

  AST_REACT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == PIN_SRC_REACT) |=> (pin_o == $past(src_i[PIN_SRC_REACT]))); // R2

endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
  import ir_tx_pkg::*;
#(
  parameter int unsigned PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_tick_i,
  input  logic              tx_bit_i,
  input  logic              tx_invert_i,
  input  logic              mod_enable_i,
  input  logic [DUTY_W-1:0] duty_code_i,
  input  logic [SEL_W-1:0]  pin_sel_i,
  input  logic              gpo_bit_i,
  input  logic              real_pulse_i,
  input  logic              react_pulse_i,
  output logic              pin_o
);

  logic            carrier_low;
  logic            shaped;
  logic [NSRC-1:0] sources;

  ir_carrier_gen #(.PHASE_W(PHASE_W)) i_carrier (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (carrier_tick_i),
    .duty_i        (duty_code_i),
    .carrier_low_o (carrier_low)
  );

  ir_tx_shaper i_shaper (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_bit_i      (tx_bit_i),
    .invert_i      (tx_invert_i),
    .mod_en_i      (mod_enable_i),
    .carrier_low_i (carrier_low),
    .shaped_o      (shaped)
  );

  always_comb begin
    sources                = '0;
    sources[PIN_SRC_TXD]   = shaped;
    sources[PIN_SRC_GPO]   = gpo_bit_i;
    sources[PIN_SRC_REAL]  = real_pulse_i;
    sources[PIN_SRC_REACT] = react_pulse_i;
  end

  ir_pin_select i_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (pin_sel_i),
    .src_i (sources),
    .pin_o (pin_o)
  );

  AST_REAL_PULSE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel_i == PIN_SRC_REAL) |=> (pin_o == $past(real_pulse_i))); // R2

  AST_INVERTED_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel_i == PIN_SRC_TXD && tx_invert_i && !tx_bit_i) |=> pin_o); // R3

endmodule

// File: tb/test_ir_tx_modulator.sv
`timescale 1ns/1ps
module test_ir_tx_modulator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, txb, inv, men, gpo, rp, qp;
  logic [1:0] duty, sel;
  logic       pin;

  int checks = 0;
  int fails  = 0;

  int m_phase = 0;
  int m_duty  = 0;

  always #4 clk = ~clk;

  ir_tx_modulator i_ir_tx_modulator (
    .clk            (clk),
    .rst_n          (rst_n),
    .carrier_tick_i (tick),
    .tx_bit_i       (txb),
    .tx_invert_i    (inv),
    .mod_enable_i   (men),
    .duty_code_i    (duty),
    .pin_sel_i      (sel),
    .gpo_bit_i      (gpo),
    .real_pulse_i   (rp),
    .react_pulse_i  (qp),
    .pin_o          (pin)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pin=%b expected %b (sel=%0d inv=%b mod=%b duty=%0d tx=%b phase=%0d)",
               req, got, exp, sel, inv, men, duty, txb, m_phase, m_duty);
    end
  endtask

  // One clock: inputs set at the falling edge, pin sampled 2 ns after the rise.
  task automatic step(input logic t, input logic x, input logic g,
                      input logic r, input logic q);
    logic  lvl, exp;
    int    low_len;
    string tag;
    tick = t; txb = x; gpo = g; rp = r; qp = q;
    @(posedge clk);
    lvl     = x ^ inv;
    low_len = 8 >> m_duty;                       // R5 low lengths 8/4/2/1
    case (sel)
      2'd0: exp = (men && !lvl) ? (m_phase >= low_len) : lvl;
      2'd1: exp = g;
      2'd2: exp = r;
      default: exp = q;
    endcase
    if (sel != 2'd0)                      tag = "R2";
    else if (men && lvl)                  tag = "R4";
    else if (men && m_duty != int'(duty)) tag = "R7";
    else if (men && !t)                   tag = "R6";
    else if (men)                         tag = "R5";
    else if (inv)                         tag = "R3";
    else                                  tag = "R8";
    if (t) begin
      if (m_phase == 15) m_duty = int'(duty);
      m_phase = (m_phase + 1) % 16;
    end
    #2;
    check(tag, pin, exp);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick = 0; txb = 0; inv = 0; men = 0; gpo = 0; rp = 0; qp = 0;
    duty = 2'd0; sel = 2'd0;
    repeat (3) @(negedge clk);
    check("R1", pin, 1'b1);                      // R1 pin high in reset
    rst_n = 1'b1;

    // R5: clean full periods per duty code, mark level held at 0
    men = 1;
    for (int d = 0; d < 4; d++) begin
      duty = 2'(d);
      for (int j = 0; j < 48; j++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R6: ticks withheld, phase must freeze
    duty = 2'd0;
    for (int j = 0; j < 40; j++) step(j % 4 == 0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Full sweep over select, invert, modulation and duty
    for (int s = 0; s < 4; s++)
      for (int iv = 0; iv < 2; iv++)
        for (int me = 0; me < 2; me++)
          for (int d = 0; d < 4; d++) begin
            sel = 2'(s); inv = iv[0]; men = me[0]; duty = 2'(d);
            for (int j = 0; j < 40; j++)
              step(j % 7 != 6, 1'((j / 3) % 2) ^ 1'((j / 11) % 2),
                   1'(j % 2), 1'((j / 2) % 2), 1'((j / 4) % 2));
          end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule